// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block turns one warp-wide memory request into the smallest set of aligned memory transactions that covers every active lane. A request has 32 lane addresses, one mask bit per lane and a load/store flag. Lanes whose addresses fall inside the same aligned segment share one transaction. The segment size is chosen per request: 128 bytes in cached mode, 32 bytes in segment mode.

Transactions leave one per cycle on a valid/ready handshake. Each one carries its aligned base address, a size bit, the store flag and a 32-bit mask of the lanes it serves. The block builds transactions on the fly from the lanes not yet served. It takes the lowest such lane as the leader, finds every lane in the leader's segment, and emits that group. It accepts the next request only after it has handed off the last transaction of the current one, and it marks that point with a one-cycle done pulse.

Top module: `warp_coalescer`

## Requirements
- R1: In 128-byte mode (seg_mode=0), 32 active lanes reading consecutive 4-byte words of one aligned 128-byte region produce exactly one transaction, and its lane mask has all 32 bits set.
- R2: Every transaction base is aligned to its size. txn_size is 1 for a 128-byte transaction (seg_mode=0) and 0 for a 32-byte transaction (seg_mode=1).
- R3: Bit i of txn_lanes stands for lane i. Every active lane appears in exactly one transaction of its request, and that transaction's segment holds the lane's address.
- R4: The number of transactions for a request equals the number of distinct aligned segments touched by its active lanes. This can be up to one per lane.
- R5: Transactions come out in ascending order of the lowest lane each one serves.
- R6: Lanes whose mask bit is 0 appear in no transaction. A request with every mask bit 0 produces no transaction and still completes with a done pulse.
- R7: While txn_valid is high and txn_ready is low, the transaction fields hold steady. One transaction is handed off in each cycle in which both are high.
- R8: txn_store of every transaction equals the req_store of its request.
- R9: req_ready is low from the cycle after a request is accepted until the last transaction is handed off. done is high for exactly the one cycle after that handoff, or the cycle after an all-inactive request is accepted.
- R10: In 32-byte mode, 32 active lanes reading consecutive 4-byte words of an aligned 128-byte region produce four transactions of eight lanes each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 1024 | Lane addresses, lane i in bits [32i+31:32i] |
| req_mask | input | 32 | Active-lane mask |
| req_store | input | 1 | 1 = store, 0 = load |
| seg_mode | input | 1 | 0 = 128-byte transactions, 1 = 32-byte transactions |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_base | output | 32 | Aligned base byte address |
| txn_size | output | 1 | 1 = 128 bytes, 0 = 32 bytes |
| txn_lanes | output | 32 | Lanes served by this transaction |
| txn_store | output | 1 | Store flag of the request |
| done | output | 1 | One-cycle pulse when a request has completed |

## Verification
The bench targets several corner cases, and each one exposes a different fault.
- Fully contiguous warps in both modes. A grouping fault shows up here as a split of the single 128-byte access, or as the wrong number of 32-byte pieces.
- Lanes with descending addresses and an unaligned run that crosses a segment boundary. A block that ordered transactions by address, or aligned the base wrongly, would emit groups in the wrong order or with bad bases.
- A fully scattered warp that needs 32 transactions, and an all-inactive warp. These expose mask handling that leaks inactive lanes into groups, or a done pulse that never comes or comes at the wrong time.
- A downstream ready that toggles at random. This catches fields that change during a stall and handoffs that are lost or doubled.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {
    SZ_SMALL = 1'b0,
    SZ_LARGE = 1'b1
  } txn_size_e;
endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
  parameter int LANES = 32,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES-1:0] pending,
  output logic [LW-1:0]    lead_idx,
  output logic             any
);
  always_comb begin
    lead_idx = '0;
    any      = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) begin
        lead_idx = LW'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_matcher.sv
module coal_matcher #(
  parameter int LANES     = 32,
  parameter int AW        = 32,
  parameter int LARGE_SH  = 7,
  parameter int SMALL_SH  = 5,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES*AW-1:0] addr_flat,
  input  logic [LANES-1:0]    pending,
  input  logic [LW-1:0]       lead_idx,
  input  logic                small_mode,
  output logic [AW-1:0]       base,
  output logic [LANES-1:0]    group
);
  localparam logic [AW-1:0] LARGE_OFS = AW'((1 << LARGE_SH) - 1);
  localparam logic [AW-1:0] SMALL_OFS = AW'((1 << SMALL_SH) - 1);

  logic [AW-1:0] lead_addr;

  always_comb begin
    lead_addr = addr_flat[lead_idx*AW +: AW];
    base      = small_mode ? (lead_addr & ~SMALL_OFS) : (lead_addr & ~LARGE_OFS);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AW-1:0] lane_addr;
    logic          same_large;
    logic          same_small;
    always_comb begin
      lane_addr  = addr_flat[g*AW +: AW];
      same_large = (lane_addr[AW-1:LARGE_SH] == lead_addr[AW-1:LARGE_SH]);
      same_small = (lane_addr[AW-1:SMALL_SH] == lead_addr[AW-1:SMALL_SH]);
      group[g]   = pending[g] & (small_mode ? same_small : same_large);
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES       = 32,
  parameter int AW          = 32,
  parameter int LARGE_BYTES = 128,
  parameter int SMALL_BYTES = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES-1:0]    req_mask,
  input  logic                req_store,
  input  logic                seg_mode,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_base,
  output logic                txn_size,
  output logic [LANES-1:0]    txn_lanes,
  output logic                txn_store,
  output logic                done
);
  import coal_pkg::*;

  localparam int LARGE_SH = $clog2(LARGE_BYTES);
  localparam int SMALL_SH = $clog2(SMALL_BYTES);
  localparam int LW       = $clog2(LANES);

  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]    pend_q, pend_d;
  logic                busy_q, busy_d;
  logic                small_q;
  logic                store_q;
  logic                done_q, done_d;
  logic                load_en;
  logic                fire;
  logic                last;

  logic [LW-1:0]       lead_idx;
  logic                any_pend;
  logic [AW-1:0]       grp_base;
  logic [LANES-1:0]    grp_lanes;

  coal_leader #(.LANES(LANES)) u_leader (
    .pending  (pend_q),
    .lead_idx (lead_idx),
    .any      (any_pend)
  );

  coal_matcher #(
    .LANES(LANES), .AW(AW), .LARGE_SH(LARGE_SH), .SMALL_SH(SMALL_SH)
  ) u_matcher (
    .addr_flat  (addr_q),
    .pending    (pend_q),
    .lead_idx   (lead_idx),
    .small_mode (small_q),
    .base       (grp_base),
    .group      (grp_lanes)
  );

  always_comb begin
    req_ready = !busy_q;
    txn_valid = busy_q && any_pend;
    txn_base  = grp_base;
    txn_lanes = grp_lanes;
    txn_size  = small_q ? SZ_SMALL : SZ_LARGE;
    txn_store = store_q;
    done      = done_q;
  end

  always_comb begin
    load_en = req_valid && req_ready;
    fire    = txn_valid && txn_ready;
    last    = fire && ((pend_q & ~grp_lanes) == '0);
    pend_d  = pend_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (load_en) begin
      pend_d = req_mask;
      busy_d = (req_mask != '0);
      done_d = (req_mask == '0);
    end else if (fire) begin
      pend_d = pend_q & ~grp_lanes;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      small_q <= 1'b0;
      store_q <= 1'b0;
    end else if (load_en) begin
      addr_q  <= req_addr;
      small_q <= seg_mode;
      store_q <= req_store;
    end
  end

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_size ? (txn_base[LARGE_SH-1:0] == '0)
                            : (txn_base[SMALL_SH-1:0] == '0))); // R2
  AST_GROUP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_lanes != '0)); // R3
  AST_GROUPS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready) |=> (!txn_valid || ((txn_lanes & $past(txn_lanes)) == '0))); // R3
  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_lanes)
                                   && $stable(txn_size))); // R7
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !txn_valid)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [N*32-1:0] req_addr;
  logic [31:0]   lane_a [N];
  logic [N-1:0]  req_mask;
  logic          req_store;
  logic          seg_mode;
  logic          txn_valid;
  logic          txn_ready;
  logic [31:0]   txn_base;
  logic          txn_size;
  logic [N-1:0]  txn_lanes;
  logic          txn_store;
  logic          done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0]  q_base [$];
  logic [N-1:0] q_lanes [$];
  logic         exp_size;
  logic         exp_store;
  logic         done_due;
  logic         accepted_flag;
  int           txn_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) req_addr[i*32 +: 32] = lane_a[i];

  warp_coalescer u_warp_coalescer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .req_store(req_store),
    .seg_mode(seg_mode), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_base(txn_base), .txn_size(txn_size), .txn_lanes(txn_lanes),
    .txn_store(txn_store), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: build the expected transaction list on acceptance,
  // then compare outputs on every falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      check(done == done_due, "R9 done timing", 64'(done), 64'(done_due));
      done_due = 1'b0;
      if (txn_valid) begin
        if (q_base.size() == 0) begin
          check(1'b0, "R4 extra transaction", 64'(txn_base), 64'hffffffff);
        end else begin
          check(txn_base == q_base[0], "R2 R5 base", 64'(txn_base), 64'(q_base[0]));
          check(txn_lanes == q_lanes[0], "R3 R5 R6 lanes", 64'(txn_lanes), 64'(q_lanes[0]));
          check(txn_size == exp_size, "R2 size", 64'(txn_size), 64'(exp_size));
          check(txn_store == exp_store, "R8 store", 64'(txn_store), 64'(exp_store));
          check(!req_ready, "R9 ready low while busy", 64'(req_ready), 64'd0);
          if (txn_ready) begin
            void'(q_base.pop_front());
            void'(q_lanes.pop_front());
            txn_seen++;
            if (q_base.size() == 0) done_due = 1'b1;
          end
        end
      end
      if (req_valid && req_ready) begin
        logic [N-1:0] taken;
        int sh;
        accepted_flag = 1'b1;
        txn_seen  = 0;
        sh        = seg_mode ? 5 : 7;
        exp_size  = !seg_mode;
        exp_store = req_store;
        taken     = '0;
        for (int i = 0; i < N; i++) begin
          if (req_mask[i] && !taken[i]) begin
            logic [N-1:0] grp;
            grp = '0;
            for (int j = i; j < N; j++)
              if (req_mask[j] && ((lane_a[j] >> sh) == (lane_a[i] >> sh))) grp[j] = 1'b1;
            taken |= grp;
            q_base.push_back((lane_a[i] >> sh) << sh);
            q_lanes.push_back(grp);
          end
        end
        if (req_mask == '0) done_due = 1'b1;
      end
    end
  end

  // Random downstream ready
  initial begin
    txn_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      txn_ready = ($urandom_range(0, 3) != 0);
    end
  end

  task automatic send(input logic [N-1:0] m, input bit st, input bit md,
                      input int exp_count, input string tag);
    req_mask  = m;
    req_store = st;
    seg_mode  = md;
    req_valid = 1'b1;
    accepted_flag = 1'b0;
    do @(posedge clk); while (!accepted_flag);
    #1 req_valid = 1'b0;
    while (!(q_base.size() == 0 && req_ready && !done_due)) @(posedge clk);
    @(negedge clk);
    if (exp_count >= 0)
      check(txn_seen == exp_count, tag, 64'(txn_seen), 64'(exp_count));
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mask = '0; req_store = 1'b0; seg_mode = 1'b0;
    done_due = 1'b0; accepted_flag = 1'b0; txn_seen = 0; exp_size = 1'b1; exp_store = 1'b0;
    for (int i = 0; i < N; i++) lane_a[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(req_ready && !txn_valid && !done, "reset state", {req_ready, txn_valid, done}, 64'h4);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: contiguous, aligned, large mode
    for (int i = 0; i < N; i++) lane_a[i] = 32'h0000_1000 + 4 * i;
    send('1, 1'b0, 1'b0, 1, "R1 contiguous large count");
    // R10: same addresses, small mode
    send('1, 1'b1, 1'b1, 4, "R10 contiguous small count");
    // R4: fully scattered
    for (int i = 0; i < N; i++) lane_a[i] = 32'h0002_0000 + 128 * i + 4;
    send('1, 1'b0, 1'b0, 32, "R4 scattered count");
    // R6: all inactive
    send('0, 1'b0, 1'b0, 0, "R6 empty request");
    // R6: partial mask over scattered
    send(32'h0000_00F1, 1'b1, 1'b0, 5, "R6 partial mask count");
    // R5: descending addresses
    for (int i = 0; i < N; i++) lane_a[i] = 32'h0000_8000 - 16 * i;
    send('1, 1'b0, 1'b1, -1, "R5 descending");
    send('1, 1'b0, 1'b0, -1, "R5 descending large");
    // R2: unaligned run crossing a boundary
    for (int i = 0; i < N; i++) lane_a[i] = 32'h0000_0040 + 4 * i;
    send('1, 1'b0, 1'b0, 2, "R2 straddle count");
    // R3 R8: random patterns
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < N; i++) lane_a[i] = 32'h0001_0000 + ($urandom_range(0, 15) << 5) + ($urandom_range(0, 7) << 2);
      send($urandom, $urandom_range(0, 1), $urandom_range(0, 1), -1, "R3 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule